// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of on-chip peripheral interrupt sources, two external interrupt request pins and one external fast-interrupt pin. It produces a normal interrupt line and a fast interrupt line for a processor. Each normal source has its own enable bit, a 3-bit priority, a trigger mode and a vector value, all held in a small register file behind a simple read/write port. An internal source is level-sensitive or edge-triggered. An external source can be high-level, low-level, rising-edge or falling-edge sensitive.

Software reads a vector register to learn which source to serve. That read acknowledges the winning source: its edge latch is cleared and its priority becomes the new in-service level on a stack. While a level is in service, only strictly higher priorities raise the normal interrupt line, so a handler can be nested inside another. Writing the end-of-interrupt register pops the stack and returns to the level that was in service before. The fast line is fed only by its dedicated pin, gated by one enable bit, and never goes through the priority logic.

Sources are numbered with the internal ones first (0 to NUM_INT-1), followed by the external pins. Register reads return data combinationally in the same cycle as the read strobe. Any side effect of a read or write takes place at the clock edge that samples the strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are low, the enable register (address 0x0) reads 0 and the level register (address 0x4) reads 0.
- R2: A source whose enable bit (address 0x0, bit i for source i) is 0 never causes irq_o, whatever its pending state.
- R3: A read of the vector register (address 0x2) returns, in bits [7:0], the vector of the enabled pending source with the highest priority. When priorities are equal, the lowest source number wins.
- R4: Each source has a configuration word at address 0x8+i: priority in bits [2:0], mode in bits [5:4], vector in bits [15:8]. For an internal source, mode bit 5 selects rising-edge (1) or active-high level (0), and mode bit 4 is ignored. A latched edge stays pending after the input falls. The pending register (address 0x1, bit i) shows the pending state regardless of enable.
- R5: An external source decodes mode 00 as active-high level, 01 as active-low level, 10 as rising edge and 11 as falling edge.
- R6: A vector read while irq_o is high acknowledges the selected source. Its edge latch is cleared and its priority is pushed as the in-service level. The level register reports the stack depth in bits [3:0] and the in-service priority in bits [6:4]; both read 0 when the stack is empty.
- R7: irq_o is high only when an enabled pending source exists and either the stack is empty or that source's priority is strictly greater than the in-service priority.
- R8: A write to the end-of-interrupt register (address 0x3) pops one level and restores the previous in-service priority. On an empty stack the write has no effect.
- R9: A vector read while irq_o is low returns all ones (0xFF) in the vector field and leaves the stack unchanged.
- R10: fiq_o equals fiq_pin_i AND enable register bit 31. It does not depend on the normal sources or the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src_i | input | NUM_INT | On-chip peripheral interrupt sources |
| ext_irq_i | input | NUM_EXT | External interrupt request pins, synchronous to clk |
| fiq_pin_i | input | 1 | External fast interrupt pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
A stale edge latch appears at the ports in two ways. The pending register shows a stuck bit at the next read. irq_o is also raised again in the cycle right after the end-of-interrupt write that should have let it drop. A wrong stack top shows up the same cycle as irq_o being high or low against the in-service threshold. The level register exposes it on the next read, so nested sequences check the depth and priority after every push and pop. A wrong choice by the arbiter appears as a wrong vector on the very read that acknowledges it. Ties and mixed priorities are therefore read back directly.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_PEND   = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_VECTOR = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_EOI    = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_LEVEL  = 4'h4;
  localparam int CFG0 = 8;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // internal sources lose the polarity bit
  function automatic logic [1:0] trig_eff(logic [1:0] mode, logic is_ext);
    return is_ext ? mode : {mode[1], 1'b0};
  endfunction

  function automatic logic edge_seen(logic falling, logic prev, logic cur);
    return falling ? (prev & ~cur) : (~prev & cur);
  endfunction

  function automatic logic level_seen(logic active_low, logic cur);
    return cur ^ active_low;
  endfunction
endpackage

// File: rtl/irqv_src_cond.sv
module irqv_src_cond
  import irqv_pkg::*;
#(
  parameter bit IS_EXT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic [1:0] eff;
  logic       prev_q;
  logic       latch_q;
  logic       hit;

  assign eff = trig_eff(mode_i, IS_EXT);
  assign hit = edge_seen(eff[0], prev_q, src_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (eff[1] && hit)         latch_q <= 1'b1;
      else if (clr_i || !eff[1]) latch_q <= 1'b0;
    end
  end

  assign pend_o = eff[1] ? latch_q : level_seen(eff[0], src_i);
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NSRC   = 6,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [PRIO_W-1:0]      prio_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (req_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqv_level_stack.sv
module irqv_level_stack #(
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 8,
  parameter int LW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_lvl_i,
  input  logic              pop_i,
  output logic [LW-1:0]     depth_o,
  output logic [PRIO_W-1:0] top_o
);
  localparam int IW = $clog2(DEPTH);

  logic [PRIO_W-1:0] stk_q [DEPTH];
  logic [LW-1:0]     depth_q;
  logic              do_push;

  assign do_push = push_i && (depth_q < LW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       depth_q <= '0;
    else if (do_push)                 depth_q <= depth_q + 1'b1;
    else if (pop_i && depth_q != '0)  depth_q <= depth_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) stk_q[IW'(depth_q)] <= push_lvl_i;
  end

  assign depth_o = depth_q;
  assign top_o   = (depth_q == '0) ? '0 : stk_q[IW'(depth_q - 1'b1)];
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 2,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_src_i,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic               fiq_pin_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NSRC     = NUM_INT + NUM_EXT;
  localparam int DEPTH    = 2 ** PRIO_W;
  localparam int LW       = $clog2(DEPTH + 1);
  localparam int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int MODE_LSB = 4;
  localparam int VEC_LSB  = 8;
  localparam int LVL_LSB  = 4;

  logic [NSRC-1:0]        src_raw;
  logic [NSRC-1:0]        en_q;
  logic                   fiq_en_q;
  logic [PRIO_W-1:0]      prio_q [NSRC];
  logic [1:0]             mode_q [NSRC];
  logic [VEC_W-1:0]       vec_q  [NSRC];
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        pend;
  logic [NSRC-1:0]        cand;
  logic [NSRC-1:0]        clr_vec;
  logic                   any_cand;
  logic [IDX_W-1:0]       best_idx;
  logic [PRIO_W-1:0]      best_prio;
  logic [LW-1:0]          depth;
  logic [PRIO_W-1:0]      cur_level;
  logic                   vec_rd, ack_evt, spur_evt, eoi_evt;
  logic                   unused_wdata;

  assign src_raw      = {ext_irq_i, int_src_i};
  assign unused_wdata = &{1'b0, reg_wdata_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      fiq_en_q <= 1'b0;
    end else if (reg_we_i && reg_addr_i == ADR_ENABLE) begin
      en_q     <= reg_wdata_i[NSRC-1:0];
      fiq_en_q <= reg_wdata_i[DATA_W-1];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
        mode_q[i] <= TRIG_HIGH;
        vec_q[i]  <= '0;
      end else if (reg_we_i && reg_addr_i == ADDR_W'(CFG0 + i)) begin
        prio_q[i] <= reg_wdata_i[PRIO_W-1:0];
        mode_q[i] <= reg_wdata_i[MODE_LSB +: 2];
        vec_q[i]  <= reg_wdata_i[VEC_LSB +: VEC_W];
      end
    end

    irqv_src_cond #(.IS_EXT(i >= NUM_INT)) u_cond (
      .clk(clk), .rst_n(rst_n), .src_i(src_raw[i]), .mode_i(mode_q[i]),
      .clr_i(clr_vec[i]), .pend_o(pend[i])
    );

    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  assign cand = pend & en_q;

  irqv_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .req_i(cand), .prio_i(prio_flat), .any_o(any_cand),
    .idx_o(best_idx), .prio_o(best_prio)
  );

  assign irq_o    = any_cand && (depth == '0 || best_prio > cur_level);
  assign fiq_o    = fiq_pin_i && fiq_en_q;
  assign vec_rd   = reg_re_i && reg_addr_i == ADR_VECTOR;
  assign ack_evt  = vec_rd && irq_o;
  assign spur_evt = vec_rd && !irq_o;
  assign eoi_evt  = reg_we_i && reg_addr_i == ADR_EOI;
  assign clr_vec  = ack_evt ? (NSRC'(1) << best_idx) : '0;

  irqv_level_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH), .LW(LW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(ack_evt), .push_lvl_i(best_prio),
    .pop_i(eoi_evt), .depth_o(depth), .top_o(cur_level)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_ENABLE: begin
        reg_rdata_o[NSRC-1:0]   = en_q;
        reg_rdata_o[DATA_W-1]   = fiq_en_q;
      end
      ADR_PEND:   reg_rdata_o[NSRC-1:0] = pend;
      ADR_VECTOR: reg_rdata_o[VEC_W-1:0] = irq_o ? vec_q[best_idx] : '1;
      ADR_LEVEL: begin
        reg_rdata_o[LW-1:0]             = depth;
        reg_rdata_o[LVL_LSB +: PRIO_W]  = cur_level;
      end
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (reg_addr_i == ADDR_W'(CFG0 + i)) begin
            reg_rdata_o[PRIO_W-1:0]        = prio_q[i];
            reg_rdata_o[MODE_LSB +: 2]     = mode_q[i];
            reg_rdata_o[VEC_LSB +: VEC_W]  = vec_q[i];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int PRIO_W = 3,
  parameter int LW     = 4,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              fiq_pin_i,
  input logic              any_cand,
  input logic              ack_evt,
  input logic              eoi_evt,
  input logic              spur_evt,
  input logic [LW-1:0]     depth,
  input logic [PRIO_W-1:0] cur_level
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= LW'(DEPTH));

  // R6
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> depth == LW'($past(depth) + 1'b1));

  // R7
  nest_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && depth != '0) |=> cur_level > $past(cur_level));

  // R8
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && depth != '0) |=> depth == LW'($past(depth) - 1'b1));

  // R8
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && depth == '0) |=> depth == '0);

  // R9
  spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spur_evt |=> $stable(depth) && $stable(cur_level));

  // R2
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> any_cand);

  // R10
  fiq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> fiq_pin_i);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.PRIO_W(PRIO_W), .LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o), .fiq_pin_i(fiq_pin_i),
  .any_cand(any_cand), .ack_evt(ack_evt), .eoi_evt(eoi_evt), .spur_evt(spur_evt),
  .depth(depth), .cur_level(cur_level)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  int_src = '0;
  logic [1:0]  ext_irq = '0;
  logic        fiq_pin = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_irq_i(ext_irq),
    .fiq_pin_i(fiq_pin), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  localparam logic [3:0] A_EN = 4'h0, A_PEND = 4'h1, A_VEC = 4'h2, A_EOI = 4'h3, A_LVL = 4'h4;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (rst_n && re) begin
      if (exp_q.size() == 0) check("scoreboard empty", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    re = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    tick();
    re = 1'b0;
  endtask

  task automatic pin(string tag, logic act_sel, logic exp);
    #1;
    check(tag, {31'b0, act_sel ? fiq : irq}, {31'b0, exp});
    #3;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    pin("R1 irq", 1'b0, 1'b0);
    pin("R1 fiq", 1'b1, 1'b0);
    rd(A_EN, 32'h0, "R1 enable");
    rd(A_LVL, 32'h0, "R1 level");
    // config: {vector, mode, prio}
    wr(4'h8, 32'h1002);
    wr(4'h9, 32'h1102);
    wr(4'hA, 32'h1225);
    wr(4'hB, 32'h1311);
    wr(4'hC, 32'h1406);
    wr(4'hD, 32'h1503);
    rd(4'hA, 32'h1225, "R4 cfg readback");

    // R2 masking, R3, R6, R7, R8
    int_src[0] = 1'b1;
    pin("R2 masked", 1'b0, 1'b0);
    wr(A_EN, 32'h1);
    pin("R2 enabled", 1'b0, 1'b1);
    rd(A_VEC, 32'h10, "R3 single");
    rd(A_LVL, 32'h21, "R6 level after ack");
    pin("R7 equal level blocked", 1'b0, 1'b0);
    wr(A_EOI, 0);
    pin("R8 irq after eoi", 1'b0, 1'b1);
    rd(A_LVL, 32'h0, "R8 level popped");

    // R3 tie
    int_src[1] = 1'b1;
    wr(A_EN, 32'h3);
    rd(A_VEC, 32'h10, "R3 tie lowest index");
    wr(A_EOI, 0);
    int_src[0] = 1'b0;
    rd(A_VEC, 32'h11, "R3 remaining");
    wr(A_EOI, 0);
    int_src = '0;

    // R3 priority with R4 edge latch
    int_src[0] = 1'b1;
    int_src[2] = 1'b1;
    tick();
    int_src[2] = 1'b0;
    wr(A_EN, 32'h5);
    rd(A_PEND, 32'h05, "R4 edge latched");
    rd(A_VEC, 32'h12, "R3 higher priority");
    rd(A_PEND, 32'h01, "R6 latch cleared");
    rd(A_LVL, 32'h51, "R6 level prio5");
    pin("R7 lower blocked", 1'b0, 1'b0);
    wr(A_EOI, 0);
    rd(A_VEC, 32'h10, "R3 after eoi");
    wr(A_EOI, 0);
    int_src = '0;
    pin("R4 level dropped", 1'b0, 1'b0);

    // R4 internal polarity bit ignored
    wr(A_EN, 32'h8);
    int_src[3] = 1'b1;
    pin("R4 int active high", 1'b0, 1'b1);
    int_src[3] = 1'b0;
    pin("R4 int inactive", 1'b0, 1'b0);

    // R5 external modes on source 4
    wr(A_EN, 32'h0);
    wr(4'hC, 32'h1416);
    rd(A_PEND, 32'h10, "R5 low level");
    wr(4'hC, 32'h1406);
    rd(A_PEND, 32'h00, "R5 high level idle");
    ext_irq[0] = 1'b1;
    rd(A_PEND, 32'h10, "R5 high level");
    wr(4'hC, 32'h1436);
    rd(A_PEND, 32'h00, "R5 fall idle");
    ext_irq[0] = 1'b0;
    tick();
    rd(A_PEND, 32'h10, "R5 falling edge");
    wr(A_EN, 32'h10);
    rd(A_VEC, 32'h14, "R5 vector");
    rd(A_PEND, 32'h00, "R6 ext latch cleared");
    wr(A_EOI, 0);
    wr(4'hC, 32'h1426);
    ext_irq[0] = 1'b1;
    tick();
    rd(A_PEND, 32'h10, "R5 rising edge");
    rd(A_VEC, 32'h14, "R5 rise vector");
    rd(A_PEND, 32'h00, "R6 no relatch while high");
    wr(A_EOI, 0);
    ext_irq[0] = 1'b0;
    wr(4'hC, 32'h1406);

    // R6/R7/R8 nesting
    int_src[0] = 1'b1;
    wr(A_EN, 32'h31);
    rd(A_VEC, 32'h10, "R6 outer");
    ext_irq[0] = 1'b1;
    pin("R7 higher preempts", 1'b0, 1'b1);
    rd(A_VEC, 32'h14, "R6 nested vector");
    rd(A_LVL, 32'h62, "R6 depth2 prio6");
    ext_irq[1] = 1'b1;
    pin("R7 prio3 under 6", 1'b0, 1'b0);
    ext_irq[0] = 1'b0;
    wr(A_EOI, 0);
    rd(A_LVL, 32'h21, "R8 restored prio2");
    pin("R8 prio3 now above", 1'b0, 1'b1);
    rd(A_VEC, 32'h15, "R6 second nest");
    rd(A_LVL, 32'h32, "R6 depth2 prio3");
    wr(A_EOI, 0);
    rd(A_LVL, 32'h21, "R8 pop");
    wr(A_EOI, 0);
    rd(A_LVL, 32'h00, "R8 empty");
    wr(A_EOI, 0);
    rd(A_LVL, 32'h00, "R8 eoi on empty");
    int_src = '0;
    ext_irq = '0;

    // R9 spurious
    pin("R9 idle", 1'b0, 1'b0);
    rd(A_VEC, 32'hFF, "R9 spurious vector");
    rd(A_LVL, 32'h00, "R9 level unchanged");

    // R10 fast line
    fiq_pin = 1'b1;
    pin("R10 fiq disabled", 1'b1, 1'b0);
    wr(A_EN, 32'h8000_0000);
    pin("R10 fiq on", 1'b1, 1'b1);
    pin("R10 irq unaffected", 1'b0, 1'b0);
    rd(A_VEC, 32'hFF, "R10 vector unaffected");
    fiq_pin = 1'b0;
    pin("R10 fiq off", 1'b1, 1'b0);

    tick();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule